// File: doc/BRIEF.md
# Ternary Weight Dot-Product Engine

This block forms the dot product of a stream of signed 8-bit activations with a vector of ternary weights, each weight being -1, 0 or +1 and held as a 2-bit code. It contains no per-element multiplier. A +1 weight adds the activation to a positive-side sum. A -1 weight adds the activation to a separate negative-side sum. A zero weight leaves both sums untouched and increments a skip counter instead.

Once the last element has been consumed, the engine scales the two sums independently and subtracts them. The positive sum is multiplied by an unsigned positive scale, and the negative sum by an unsigned negative scale. These two scales are per-layer or per-channel configuration values.

A start pulse loads a packed weight word, the vector length and both scales. Activations are then offered one per clock with a valid strobe, and a single-cycle result strobe marks the finished value.

Top module: `ternary_dot_engine`

## Requirements
- R1: Weight element i sits in bits [2i+1:2i] of the weight word. Code 2'b01 means +1 and adds the activation to the positive sum. Code 2'b11 means -1 and adds the activation to the negative sum. Code 2'b00 means zero.
- R2: An element whose code is 2'b00 or the reserved 2'b10 changes neither sum and increments skip_count by one.
- R3: result equals pos_scale × (positive sum) − neg_scale × (negative sum). It is a signed 25-bit value with no rounding, and the scales are unsigned.
- R4: While busy, one element is consumed on each clock edge where act_valid is high. While act_valid is low, or while idle, no element is consumed.
- R5: The vector length is len_cfg + 1. result_valid is high for exactly one cycle, which is the cycle after the edge that consumes the last element. busy falls on that same edge.
- R6: A start pulse accepted while idle clears both sums and skip_count, latches the weights, length and scales, and raises busy on the next cycle.
- R7: A start pulse while busy is ignored: the running vector, its latched configuration and skip_count are unaffected.
- R8: Consuming a reserved 2'b10 code sets code_error. code_error stays set until reset.
- R9: After reset, busy, result_valid, code_error, skip_count and result are all zero.
- R10: Changing the weight, length or scale inputs after start has been accepted has no effect on the running vector's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new vector (accepted only when idle) |
| len_cfg | input | LEN_W | Vector length minus one |
| weights | input | 2*MAX_LEN | Packed 2-bit ternary codes |
| pos_scale | input | SCALE_W | Unsigned scale for the positive sum |
| neg_scale | input | SCALE_W | Unsigned scale for the negative sum |
| act_valid | input | 1 | Activation present on act_data |
| act_data | input | ACT_W | Signed activation |
| busy | output | 1 | Vector in progress |
| result_valid | output | 1 | One-cycle strobe for a finished result |
| result | output | RES_W | Signed scaled dot product |
| skip_count | output | CNT_W | Zero or reserved weights skipped in this vector |
| code_error | output | 1 | Sticky flag for the reserved weight code |

## Verification
The bench builds the engine with MAX_LEN = 4, which makes every one of the 256 four-element code patterns (reserved code included) reachable. Each pattern is paired with distinct activations and scale pairs, and the expected result and skip count are computed arithmetically. The small build also makes short lengths, stalls in act_valid, extreme activations with full-scale factors, and mid-vector changes to start and configuration cheap to cover, each with its exact expected value.

// File: rtl/ternary_dot_engine.sv
module ternary_dot_engine #(
  parameter int ACT_W   = 8,
  parameter int MAX_LEN = 64,
  parameter int SCALE_W = 8,
  parameter int SUM_W   = 16,
  parameter int RES_W   = 25,
  localparam int LEN_W  = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LEN_W-1:0]         len_cfg,
  input  logic [2*MAX_LEN-1:0]     weights,
  input  logic [SCALE_W-1:0]       pos_scale,
  input  logic [SCALE_W-1:0]       neg_scale,
  input  logic                     act_valid,
  input  logic signed [ACT_W-1:0]  act_data,
  output logic                     busy,
  output logic                     result_valid,
  output logic signed [RES_W-1:0]  result,
  output logic [CNT_W-1:0]         skip_count,
  output logic                     code_error
);

  logic [2*MAX_LEN-1:0]    w_q;
  logic [LEN_W-1:0]        len_q, idx;
  logic [SCALE_W-1:0]      ps_q, ns_q;
  logic signed [SUM_W-1:0] pos_sum, neg_sum;
  logic [1:0]              code;
  logic                    take, last;
  logic signed [SUM_W-1:0] act_ext;
  logic signed [RES_W-1:0] pos_prod, neg_prod;

  assign code    = w_q[{idx, 1'b0} +: 2];
  assign take    = busy & act_valid;
  assign last    = (idx == len_q);
  assign act_ext = SUM_W'(act_data);

  assign pos_prod = $signed({{(RES_W-SCALE_W){1'b0}}, ps_q}) * RES_W'(pos_sum);
  assign neg_prod = $signed({{(RES_W-SCALE_W){1'b0}}, ns_q}) * RES_W'(neg_sum);
  assign result   = pos_prod - neg_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q          <= '0;
      len_q        <= '0;
      ps_q         <= '0;
      ns_q         <= '0;
      idx          <= '0;
      pos_sum      <= '0;
      neg_sum      <= '0;
      skip_count   <= '0;
      busy         <= 1'b0;
      result_valid <= 1'b0;
      code_error   <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (start && !busy) begin
        w_q        <= weights;
        len_q      <= len_cfg;
        ps_q       <= pos_scale;
        ns_q       <= neg_scale;
        idx        <= '0;
        pos_sum    <= '0;
        neg_sum    <= '0;
        skip_count <= '0;
        busy       <= 1'b1;
      end else if (take) begin
        unique case (code)
          2'b01:   pos_sum <= pos_sum + act_ext;
          2'b11:   neg_sum <= neg_sum + act_ext;
          default: skip_count <= skip_count + 1'b1;
        endcase
        if (code == 2'b10) code_error <= 1'b1;
        idx <= idx + 1'b1;
        if (last) begin
          busy         <= 1'b0;
          result_valid <= 1'b1;
        end
      end
    end
  end

endmodule

module ternary_dot_engine_props #(
  parameter int CNT_W = 7,
  parameter int RES_W = 25
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    act_valid,
  input logic                    busy,
  input logic                    result_valid,
  input logic signed [RES_W-1:0] result,
  input logic [CNT_W-1:0]        skip_count,
  input logic                    code_error
);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_strobe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !busy);

  p_error_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_error |=> code_error);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(skip_count) && $stable(result) && !busy));

  p_start_busy_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !act_valid) |=> ($stable(skip_count) && busy));

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && skip_count == '0 && result == '0));

endmodule

bind ternary_dot_engine ternary_dot_engine_props #(.CNT_W(CNT_W), .RES_W(RES_W)) u_props (
  .clk(clk), .rst_n(rst_n), .start(start), .act_valid(act_valid), .busy(busy),
  .result_valid(result_valid), .result(result), .skip_count(skip_count),
  .code_error(code_error)
);

// File: tb/ternary_dot_engine_test.sv
module ternary_dot_engine_test;
  localparam int N  = 4;
  localparam int LW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic clk = 0, rst_n = 0, start = 0, act_valid = 0;
  logic [LW-1:0] len_cfg = '0;
  logic [2*N-1:0] weights = '0;
  logic [7:0] pos_scale = '0, neg_scale = '0;
  logic signed [7:0] act_data = '0;
  logic busy, result_valid, code_error;
  logic signed [24:0] result;
  logic [CW-1:0] skip_count;

  int checks = 0, errors = 0;
  int acts [N];

  always #4 clk = ~clk;

  ternary_dot_engine #(.MAX_LEN(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_cfg(len_cfg), .weights(weights),
    .pos_scale(pos_scale), .neg_scale(neg_scale), .act_valid(act_valid),
    .act_data(act_data), .busy(busy), .result_valid(result_valid), .result(result),
    .skip_count(skip_count), .code_error(code_error));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode: 0 plain, 1 stall gaps, 2 disturb start/config mid-vector
  task automatic run_vec(input int len, input logic [2*N-1:0] w, input int ps,
                         input int ns, input int mode);
    longint p = 0, q = 0, exp;
    int sk = 0;
    for (int i = 0; i < len; i++) begin
      case (w[2*i +: 2])
        2'b01: p += acts[i];
        2'b11: q += acts[i];
        default: sk++;
      endcase
    end
    exp = ps * p - ns * q;
    @(negedge clk);
    start = 1; len_cfg = LW'(len - 1); weights = w;
    pos_scale = 8'(ps); neg_scale = 8'(ns);
    @(negedge clk);
    start = 0;
    check("R6 busy after start", busy, 1);
    check("R6 skip cleared", skip_count, 0);
    for (int i = 0; i < len; i++) begin
      if (mode == 1) begin
        act_valid = 0; act_data = 8'sd99;
        @(negedge clk);
      end
      if (mode == 2 && i == 0) begin
        start = 1; weights = ~w; len_cfg = '0;
        pos_scale = 8'(ps + 1); neg_scale = 8'(ns + 3);
      end else start = 0;
      act_valid = 1; act_data = 8'(acts[i]);
      @(negedge clk);
      start = 0;
      if (i < len - 1) check("R5 no early strobe", result_valid, 0);
    end
    act_valid = 0;
    check("R5 strobe after last element", result_valid, 1);
    check("R5 busy dropped", busy, 0);
    check(mode == 2 ? "R7 R10 result under disturbance" : "R1 R3 scaled result", result, exp);
    check("R2 skip count", skip_count, sk);
    act_valid = 1; act_data = 8'sd50;
    @(negedge clk);
    act_valid = 0;
    check("R5 strobe single cycle", result_valid, 0);
    check("R4 idle activation ignored", result, exp);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 busy reset", busy, 0);
    check("R9 strobe reset", result_valid, 0);
    check("R9 error reset", code_error, 0);
    check("R9 skip reset", skip_count, 0);
    check("R9 result reset", result, 0);
    rst_n = 1;

    acts = '{10, -20, 30, -40};
    run_vec(4, 8'b11_01_00_01, 3, 5, 0);
    check("R8 no error without reserved code", code_error, 0);
    acts = '{-128, -128, -128, -128};
    run_vec(4, 8'b01_01_01_01, 255, 255, 0);
    run_vec(4, 8'b11_11_11_11, 255, 255, 0);
    acts = '{127, 127, 127, 127};
    run_vec(4, 8'b11_11_11_11, 255, 0, 0);
    run_vec(4, 8'b01_01_01_01, 255, 255, 0);
    for (int l = 1; l <= N; l++) begin
      acts = '{7, -3, 100, -77};
      run_vec(l, 8'b01_11_01_11, 17, 200, 0);
    end
    acts = '{5, 6, -7, 8};
    run_vec(4, 8'b01_11_00_01, 9, 11, 1);
    run_vec(3, 8'b00_01_11_01, 2, 4, 2);
    check("R8 error still clear", code_error, 0);

    for (int pat = 0; pat < 256; pat++) begin
      for (int i = 0; i < N; i++) acts[i] = ((pat * 37 + i * 91 + 13) % 256) - 128;
      run_vec(N, 8'(pat), (pat * 7) % 256, (pat * 13 + 5) % 256, pat % 3 == 0 ? 1 : 0);
    end
    check("R8 sticky error after reserved code", code_error, 1);
    acts = '{1, 2, 3, 4};
    run_vec(4, 8'b01_01_01_01, 1, 1, 0);
    check("R8 error persists past new start", code_error, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule